// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing controller of a 256-byte serial memory that sits on a two-wire bus. It watches already-synchronised copies of the clock line (SCL) and the data line (SDA). It drives a single enable that pulls SDA low through an open-drain pad. It picks start and stop conditions out of the two lines and checks each header byte against a fixed device code and three strap pins. It then runs one of these transfers: a byte or page write, a current-address read, a random read (a dummy write followed by a repeated start), or a sequential read.

Received write bytes leave on a byte-wide write port, which feeds a page buffer. The commit pulse that starts the cell programming is issued only on the closing stop. A persistent 8-bit pointer supplies the read address to a combinational memory model. After each commit, a cycle counter stands in for the internal programming time. While that counter runs, the slave stays silent on the bus, so the master can poll for completion.

Top module: `eeprom_link_slave`

## Requirements
- R1: After reset the slave does not pull SDA, issues no write byte and no commit, and the read pointer is 00h.
- R2: The slave acknowledges a header only when its upper four bits are 1010b and bits 3..1 equal strap_i (bit 3 = strap_i[2]). Bit 0 selects read (1) or write (0). Any other header receives no acknowledge.
- R3: In a write, the word-address byte and every data byte are acknowledged. Each data byte appears for one cycle on the write port with its target address, while SCL is low. commit_o pulses once, after a stop that follows at least one data byte. A repeated start before that stop discards the pending commit.
- R4: During a write, only the low four pointer bits advance after each data byte. A page of 16 bytes therefore wraps within itself, later bytes overwrite earlier ones, and the upper four bits stay fixed.
- R5: A read header with no preceding address returns the byte at the held pointer. The pointer then advances by one after the 8th data bit.
- R6: A write header plus a word address, followed by a repeated start and a read header, loads the pointer so that the read returns the byte at that address.
- R7: While the master acknowledges, the slave keeps sending successive bytes. The pointer advances over all 8 bits and wraps from FFh to 00h.
- R8: For BUSY_CYCLES clock cycles after a commit, no header is acknowledged, whatever its device code or direction. Once that time has passed, headers are acknowledged again.
- R9: After a byte that the master does not acknowledge, the slave drives nothing until the next start, and the pointer does not advance further. A stop during a read returns the slave to idle.
- R10: The slave changes its SDA pull only while SCL is low.
- R11: A start received partway through a byte restarts header decoding from the first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronised bus clock line |
| sda_i | input | 1 | Synchronised bus data line |
| strap_i | input | 3 | Board straps compared with header bits 3..1 |
| sda_pull_o | output | 1 | 1 = pull SDA low through the open-drain pad |
| wr_en_o | output | 1 | One-cycle strobe for a received write byte |
| wr_addr_o | output | 8 | Target address of the write byte |
| wr_data_o | output | 8 | Received write byte |
| commit_o | output | 1 | One-cycle pulse that starts the programming cycle |
| rd_addr_o | output | 8 | Current pointer, used as the read address |
| rd_data_i | input | 8 | Byte at rd_addr_o from the memory model, valid in the same cycle |

## Verification
Single-byte writes followed by random reads are run at the two ends of the array and at both sides of the 7Fh/80h midpoint. They use the data patterns 00h, FFh and alternating bits, so that a fault in address capture can be told apart from one in data shifting. Headers with the wrong straps or the wrong device code are compared against correct ones, and a header sent straight after a commit is compared against one sent after the busy time.

A sequential read across FFh, an 18-byte page write starting at 3Eh, and a read of a zero byte followed by extra clocks after a NACK each target one pointer rule. The sequential read tests the full 8-bit wrap, the page write tests the 4-bit wrap, and the extra clocks test that output is held off after a NACK. Aborted headers and aborted writes show that a restart clears the decode without starting a commit.

// File: rtl/eeprom_link_pkg.sv
// Shared types and protocol constants for the two-wire memory slave.
package eeprom_link_pkg;

    // Frame decoder states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_DEV,    // receiving header byte
        ST_WADDR,  // receiving word address
        ST_WDATA,  // receiving write data
        ST_RDATA   // shifting read data out
    } link_state_t;

    // Fixed upper nibble of the header
    localparam logic [3:0] DEV_CODE = 4'b1010;
    localparam int         STRAP_W  = 3;

endpackage

// File: rtl/twb_cond_detect.sv
// Bus event detector.
// Compares each sample of SCL/SDA with the previous one and flags clock
// edges and start/stop conditions. Assumes the inputs are already
// synchronised to clk and held for at least two clk cycles per level.
module twb_cond_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_q;
    logic sda_q;

    // Keep the previous sample of both lines (idle bus is high)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/twb_busy_timer.sv
// Programming-time model.
// Loaded by a one-cycle trigger, then reports busy for BUSY_CYCLES cycles.
module twb_busy_timer #(
    parameter int BUSY_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic busy_o
);

    localparam int             CW   = $clog2(BUSY_CYCLES + 1);
    localparam logic [CW-1:0]  LOAD = CW'(BUSY_CYCLES);

    logic [CW-1:0] remain;

    // Count down the remaining programming time
    always_ff @(posedge clk) begin
        if (!rst_n)            remain <= '0;
        else if (trig_i)       remain <= LOAD;
        else if (remain != '0) remain <= remain - 1'b1;
    end

    assign busy_o = (remain != '0);

endmodule

// File: rtl/eeprom_link_slave.sv
// Two-wire serial memory slave front end.
// Decodes headers, word addresses and data bytes from SCL/SDA, drives an
// open-drain pull enable for acknowledges and read data, keeps the access
// pointer and hands write bytes to a page buffer. Assumes rd_data_i is
// valid combinationally for rd_addr_o, and that the SCL/SDA inputs are
// synchronised and slow compared with clk.
module eeprom_link_slave
    import eeprom_link_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 4,
    parameter int BUSY_CYCLES = 400
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    input  logic [STRAP_W-1:0]  strap_i,
    output logic                sda_pull_o,
    output logic                wr_en_o,
    output logic [ADDR_W-1:0]   wr_addr_o,
    output logic [DATA_W-1:0]   wr_data_o,
    output logic                commit_o,
    output logic [ADDR_W-1:0]   rd_addr_o,
    input  logic [DATA_W-1:0]   rd_data_i
);

    localparam logic [3:0]        CNT_LAST = 4'(DATA_W - 1);
    localparam logic [3:0]        CNT_ACK  = 4'(DATA_W);
    localparam logic [3:0]        CNT_PRE  = 4'hF;
    localparam logic [PAGE_W-1:0] PG_ONE   = PAGE_W'(1);
    localparam logic [ADDR_W-1:0] PT_ONE   = ADDR_W'(1);

    logic scl_rise, scl_fall, start_evt, stop_evt, busy;

    link_state_t         state;
    logic [3:0]          bit_cnt;   // bit index, CNT_ACK = ack slot
    logic [DATA_W-1:0]   sh_in;
    logic [DATA_W-1:0]   sh_out;
    logic [ADDR_W-1:0]   ptr;
    logic                rd_mode, ack_drv, mack, pend;
    logic                hdr_match;

    twb_cond_detect u_det (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_evt),
        .stop_o     (stop_evt)
    );

    twb_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (commit_o),
        .busy_o (busy)
    );

    // Header accepted only with the right code, matching straps, and no programming running
    assign hdr_match = (sh_in[7:4] == DEV_CODE) && (sh_in[3:1] == strap_i) && !busy;

    // Frame decoder, pointer and write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= CNT_PRE;
            sh_in     <= '0;
            sh_out    <= '1;
            ptr       <= '0;
            rd_mode   <= 1'b0;
            ack_drv   <= 1'b0;
            mack      <= 1'b0;
            pend      <= 1'b0;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            commit_o  <= 1'b0;
        end else begin
            wr_en_o  <= 1'b0;
            commit_o <= 1'b0;
            if (start_evt) begin
                state   <= ST_DEV;
                bit_cnt <= CNT_PRE;
                ack_drv <= 1'b0;
                pend    <= 1'b0;
            end else if (stop_evt) begin
                state    <= ST_IDLE;
                ack_drv  <= 1'b0;
                commit_o <= pend;
                pend     <= 1'b0;
            end else if (state != ST_IDLE) begin
                if (scl_rise) begin
                    if (bit_cnt < CNT_ACK)       sh_in <= {sh_in[DATA_W-2:0], sda_i};
                    else if (bit_cnt == CNT_ACK) mack  <= ~sda_i;
                end
                if (scl_fall) begin
                    if (bit_cnt == CNT_PRE) begin
                        bit_cnt <= '0;
                    end else if (bit_cnt == CNT_LAST) begin
                        bit_cnt <= CNT_ACK;
                        unique case (state)
                            ST_DEV: begin
                                if (hdr_match) begin
                                    ack_drv <= 1'b1;
                                    rd_mode <= sh_in[0];
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end
                            ST_WADDR: begin
                                ack_drv <= 1'b1;
                                ptr     <= sh_in;
                            end
                            ST_WDATA: begin
                                ack_drv   <= 1'b1;
                                wr_en_o   <= 1'b1;
                                wr_addr_o <= ptr;
                                wr_data_o <= sh_in;
                                ptr       <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PG_ONE};
                                pend      <= 1'b1;
                            end
                            ST_RDATA: begin
                                ptr  <= ptr + PT_ONE;
                                mack <= 1'b0;
                            end
                            default: ;
                        endcase
                    end else if (bit_cnt == CNT_ACK) begin
                        ack_drv <= 1'b0;
                        bit_cnt <= '0;
                        unique case (state)
                            ST_DEV: begin
                                if (rd_mode) begin
                                    state  <= ST_RDATA;
                                    sh_out <= rd_data_i;
                                end else begin
                                    state <= ST_WADDR;
                                end
                            end
                            ST_WADDR: state <= ST_WDATA;
                            ST_RDATA: begin
                                if (mack) sh_out <= rd_data_i;
                                else      state  <= ST_IDLE;
                            end
                            default: ;
                        endcase
                    end else begin
                        bit_cnt <= bit_cnt + 4'd1;
                        if (state == ST_RDATA) sh_out <= {sh_out[DATA_W-2:0], 1'b1};
                    end
                end
            end
        end
    end

    // Pull SDA for an acknowledge, or for a 0 bit while sending read data
    assign sda_pull_o = ack_drv |
                        ((state == ST_RDATA) && (bit_cnt < CNT_ACK) && !sh_out[DATA_W-1]);
    assign rd_addr_o  = ptr;

endmodule

// File: rtl/eeprom_link_checks.sv
// Protocol checker for eeprom_link_slave, attached by bind.
// Observes the bus lines, the pull enable, the write port and the busy timer.
module eeprom_link_checks (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_i,
    input logic sda_pull_o,
    input logic wr_en_o,
    input logic commit_o,
    input logic busy
);

    // R10: the pull enable moves only while the clock line is low
    p_pull_moves_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull_o) |-> !scl_i);

    // R8: silent on the bus during the programming time
    p_silent_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_pull_o);

    // R8: a commit is followed by the busy time
    p_busy_after_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> busy);

    // R3: a commit comes straight after a stop on the bus
    p_commit_on_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |-> ($past(scl_i) && $past(scl_i, 2) && $past(sda_i) && !$past(sda_i, 2)));

    // R3: write bytes are handed over while the clock line is low
    p_wr_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !scl_i);

    // R3: a write strobe and a commit never share a cycle
    p_wr_commit_apart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_en_o, commit_o}));

endmodule

bind eeprom_link_slave eeprom_link_checks u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_pull_o (sda_pull_o),
    .wr_en_o    (wr_en_o),
    .commit_o   (commit_o),
    .busy       (busy)
);

// File: tb/tb_eeprom_link_slave.sv
// Bench for eeprom_link_slave: a vector table of write/read-back pairs, then directed tests.
module tb_eeprom_link_slave;

    localparam int         BUSY  = 400;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] HDR_W = {4'b1010, STRAP, 1'b0};
    localparam logic [7:0] HDR_R = {4'b1010, STRAP, 1'b1};
    // {address, data}
    localparam logic [15:0] VEC [0:5] = '{16'h00A5, 16'h7F3C, 16'h80C3,
                                          16'hFF5A, 16'h4200, 16'h10FF};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_pull, wr_en, commit;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    wire  sda_line = m_sda & ~sda_pull;

    logic [7:0] mem   [0:255];
    logic [7:0] refm  [0:255];
    logic [7:0] wlog  [0:255];
    logic [7:0] wcnt;
    int         ccnt;
    int         n_chk = 0, n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    eeprom_link_slave #(.BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .strap_i(STRAP),
        .sda_pull_o(sda_pull), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .commit_o(commit), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    assign rd_data = mem[rd_addr];

    // Memory model, write log and commit count
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h3C;
            wcnt <= '0;
            ccnt <= 0;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wlog[wcnt]   <= wr_addr;
                wcnt         <= wcnt + 8'd1;
            end
            if (commit) ccnt <= ccnt + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic half();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_start();
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_sda = 1'b0; half(); m_scl = 1'b0; half();
    endtask

    task automatic do_stop();
        m_sda = 1'b0; half(); m_scl = 1'b1; half(); m_sda = 1'b1; half();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; half(); m_scl = 1'b1; half(); half(); m_scl = 1'b0; half();
        end
        m_sda = 1'b1; half(); m_scl = 1'b1; half(); ackd = ~sda_line; half(); m_scl = 1'b0; half();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; half(); m_scl = 1'b1; half(); b[i] = sda_line; half(); m_scl = 1'b0; half();
        end
        m_sda = ~give_ack; half(); m_scl = 1'b1; half(); half(); m_scl = 1'b0; half();
        m_sda = 1'b1;
    endtask

    // Dummy write then read one byte; returns data and header acks
    task automatic rand_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
        logic k1, k2, k3;
        do_start(); send_byte(HDR_W, k1); send_byte(a, k2);
        do_start(); send_byte(HDR_R, k3); recv_byte(1'b0, d); do_stop();
        ok = k1 & k2 & k3;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung actual=running expected=finished");
        finish_run();
    end

    initial begin : main
        logic       k, k2;
        logic [7:0] d;
        int         c0;
        logic [7:0] w0;
        for (int i = 0; i < 256; i++) refm[i] = 8'(i) ^ 8'h3C;
        repeat (5) @(negedge clk);
        // R1: reset state
        check("R1 pull", sda_pull, 0);
        check("R1 wr_en", wr_en, 0);
        check("R1 commit", commit, 0);
        check("R1 pointer", rd_addr, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // Vector table: byte write, busy poll, random read back
        for (int v = 0; v < 6; v++) begin
            logic [7:0] a, dv;
            a = VEC[v][15:8]; dv = VEC[v][7:0];
            c0 = ccnt;
            do_start(); send_byte(HDR_W, k); check("R2 write header ack", k, 1);
            send_byte(a, k); check("R3 address ack", k, 1);
            send_byte(dv, k); check("R3 data ack", k, 1);
            check("R3 no commit before stop", ccnt, c0);
            do_stop(); refm[a] = dv;
            repeat (3) @(negedge clk);
            check("R3 commit after stop", ccnt, c0 + 1);
            check("R3 write port address", wlog[wcnt - 8'd1], a);
            do_start(); send_byte(HDR_R, k); do_stop();
            check("R8 no ack while busy", k, 0);
            repeat (BUSY + 20) @(negedge clk);
            rand_read(a, d, k);
            check("R8 ack after busy", k, 1);
            check("R6 random read data", d, refm[a]);
        end

        // R2: wrong straps and wrong device code
        do_start(); send_byte({4'b1010, 3'b100, 1'b1}, k); do_stop();
        check("R2 strap mismatch no ack", k, 0);
        do_start(); send_byte({4'b0110, STRAP, 1'b0}, k); do_stop();
        check("R2 device code mismatch no ack", k, 0);

        // R5: current-address reads after last random read at 10h
        do_start(); send_byte(HDR_R, k); recv_byte(1'b0, d); do_stop();
        check("R5 current read", d, refm[8'h11]);
        do_start(); send_byte(HDR_R, k); recv_byte(1'b0, d); do_stop();
        check("R5 pointer advanced", d, refm[8'h12]);

        // R7: sequential read across FFh
        do_start(); send_byte(HDR_W, k); send_byte(8'hFE, k);
        do_start(); send_byte(HDR_R, k);
        for (int i = 0; i < 4; i++) begin
            recv_byte(i != 3, d);
            check("R7 sequential wrap", d, refm[8'(8'hFE + i)]);
        end
        do_stop();

        // R9: after NACK the slave stays off the bus; pointer stops
        do_start(); send_byte(HDR_W, k); send_byte(8'h3C, k);
        do_start(); send_byte(HDR_R, k); recv_byte(1'b0, d);
        check("R6 read of zero byte", d, 8'h00);
        recv_byte(1'b1, d);
        check("R9 silent after nack", d, 8'hFF);
        do_stop();
        do_start(); send_byte(HDR_R, k); recv_byte(1'b0, d); do_stop();
        check("R9 pointer held after nack", d, refm[8'h3D]);

        // R11: start partway through a byte restarts decoding
        do_start();
        for (int i = 0; i < 4; i++) begin
            m_sda = 1'b1; half(); m_scl = 1'b1; half(); m_scl = 1'b0; half();
        end
        do_start(); send_byte(HDR_R, k);
        check("R11 header after restart", k, 1);
        recv_byte(1'b0, d); do_stop();
        check("R11 data after restart", d, refm[8'h3E]);

        // R4: 18-byte page write from 3Eh wraps within 30h..3Fh
        c0 = ccnt; w0 = wcnt;
        do_start(); send_byte(HDR_W, k); send_byte(8'h3E, k);
        for (int i = 0; i < 18; i++) begin
            send_byte(8'(8'h20 + i), k);
            refm[{4'h3, 4'(4'hE + i)}] = 8'(8'h20 + i);
        end
        do_stop();
        repeat (3) @(negedge clk);
        check("R4 single commit", ccnt, c0 + 1);
        check("R4 third byte address", wlog[w0 + 8'd2], 8'h30);
        check("R4 last byte address", wlog[w0 + 8'd17], 8'h3F);
        repeat (BUSY + 20) @(negedge clk);
        rand_read(8'h3E, d, k);
        check("R4 overwritten byte", d, 8'h30);
        rand_read(8'h30, d, k);
        check("R4 wrapped byte", d, 8'h22);
        rand_read(8'h40, d, k);
        check("R4 next page untouched", d, refm[8'h40]);

        // R3: repeated start before the stop discards the commit
        c0 = ccnt;
        do_start(); send_byte(HDR_W, k); send_byte(8'h50, k); send_byte(8'h99, k);
        do_start(); do_stop();
        repeat (3) @(negedge clk);
        check("R3 no commit after restart", ccnt, c0);
        do_start(); send_byte(HDR_R, k2); recv_byte(1'b0, d); do_stop();
        check("R8 not busy without commit", k2, 1);

        finish_run();
    end

endmodule